// File: doc/BRIEF.md
# Associative Translation Lookaside Buffer with Access Protection

This block holds a small, fully associative set of address translations and resolves one 32-bit virtual address per lookup strobe. Each entry describes a page of one of four sizes (1 KB, 4 KB, 64 KB or 1 MB). It carries:

- a virtual page number, a physical page number and an address-space tag;
- a shared flag that bypasses the tag comparison;
- a two-bit protection field, a dirty flag and a cacheable flag.

A lookup compares the address against every entry in parallel. It combines the protection field of the single matching entry with the privilege of the access. One cycle later it reports a registered result code, the physical address and the cacheable flag.

The entries are loaded through an indexed write port. Alongside the lookup path runs a 6-bit replacement counter that software can use to choose the next slot to load. The counter advances on every lookup and wraps at a programmable boundary or at the last entry index.

Top module: `tlb_assoc_lookup`

## Requirements
- R1: An entry takes part in matching only if its valid flag is set. While tag checking is active, a non-shared entry also needs its 8-bit tag equal to `lk_asid`. An entry with the shared flag set ignores the tag.
- R2: Tag checking is active when `lk_sv` is 0 or `lk_priv` is 0. A privileged lookup with `lk_sv`=1 ignores tags.
- R3: The entry size code selects the page span: 0 = 1 KB, 1 = 4 KB, 2 = 64 KB, 3 = 1 MB. The page base is `{vpn,10'b0}` with the in-page bits cleared, and an address hits when it lies inside that page.
- R4: On result code 0 (OK), `res_paddr` equals `{ppn,10'b0}` with the in-page bits cleared, OR-ed with the in-page offset of the address, and `res_cache` is the entry's cacheable flag. For every other code, `res_paddr` and `res_cache` are 0.
- R5: When two or more entries hit, the code is 6 (multiple hit), whatever the access type.
- R6: With a single hit, let idx = {prot[1:0], lk_priv}. For idx 0 or 2, any access gives a violation: code 4 for a read, 5 for a write. For idx 1, 4 or 5, a read is allowed and a write gives code 5. For idx 3, 6 or 7, both reads and writes are allowed.
- R7: A permitted write to an entry whose dirty flag is 0 gives code 3 (initial write) instead of 0.
- R8: When no entry hits, the code is 1 for a read (`lk_write`=0) and 2 for a write.
- R9: Every lookup strobe advances `repl_count` by one. The counter returns to 0 instead when `repl_bound` is nonzero and the new count would exceed it, or when the new count would exceed ENTRIES-1. Without a strobe the counter holds. Reset clears it.
- R10: `res_valid` is 1 exactly in the cycle after a cycle with `lk_valid` high, and the code, address and cacheable flag shown then belong to that lookup.
- R11: A load with `ld_en` high writes all fields of the entry `ld_index`, and later lookups use the new contents. Reset clears every valid flag, so every lookup misses until entries are loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup strobe |
| lk_addr | input | 32 | Virtual address |
| lk_write | input | 1 | 1 = write access, 0 = read |
| lk_priv | input | 1 | Privileged access |
| lk_sv | input | 1 | Single-space mode flag (tags ignored when privileged) |
| lk_asid | input | 8 | Current address-space tag |
| res_valid | output | 1 | Result strobe, one cycle after lookup |
| res_code | output | 3 | 0 OK, 1 miss read, 2 miss write, 3 initial write, 4 violation read, 5 violation write, 6 multiple hit |
| res_paddr | output | 32 | Physical address on OK, else 0 |
| res_cache | output | 1 | Cacheable flag of the hit entry on OK, else 0 |
| ld_en | input | 1 | Load strobe |
| ld_index | input | IDX_W | Entry to load |
| ld_valid | input | 1 | Valid flag to store |
| ld_shared | input | 1 | Shared flag to store |
| ld_dirty | input | 1 | Dirty flag to store |
| ld_cache | input | 1 | Cacheable flag to store |
| ld_size | input | 2 | Size code to store |
| ld_prot | input | 2 | Protection code to store |
| ld_asid | input | 8 | Tag to store |
| ld_vpn | input | 22 | Virtual page number to store |
| ld_ppn | input | PPN_W | Physical page number to store |
| repl_bound | input | CNT_W | Replacement wrap boundary (0 = none) |
| repl_count | output | CNT_W | Replacement counter |

## Verification
The hardest case to reach is a multiple hit. The load port never rejects overlaps, so the bench creates one on purpose: it loads a 1 KB entry inside an existing 4 KB page under the same tag. It then probes an address that both entries cover, and a second address that only the larger page covers, which must still translate cleanly. The protection decode needs every {protection, privilege} pair to be reached. For this, the bench loads pages with each protection value and a clear dirty flag, then issues reads and writes in both privilege levels. The counter wrap is exercised by lowering the boundary while the count already lies above it.

// File: rtl/tlb_assoc_lookup.sv
module tlb_assoc_lookup #(
  parameter int ENTRIES = 16,
  parameter int PPN_W   = 19,
  parameter int CNT_W   = 6,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int OFF_W  = 10,
  localparam int VPN_W  = 32 - OFF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_valid,
  input  logic [31:0]      lk_addr,
  input  logic             lk_write,
  input  logic             lk_priv,
  input  logic             lk_sv,
  input  logic [7:0]       lk_asid,
  output logic             res_valid,
  output logic [2:0]       res_code,
  output logic [31:0]      res_paddr,
  output logic             res_cache,
  input  logic             ld_en,
  input  logic [IDX_W-1:0] ld_index,
  input  logic             ld_valid,
  input  logic             ld_shared,
  input  logic             ld_dirty,
  input  logic             ld_cache,
  input  logic [1:0]       ld_size,
  input  logic [1:0]       ld_prot,
  input  logic [7:0]       ld_asid,
  input  logic [VPN_W-1:0] ld_vpn,
  input  logic [PPN_W-1:0] ld_ppn,
  input  logic [CNT_W-1:0] repl_bound,
  output logic [CNT_W-1:0] repl_count
);

  localparam logic [2:0] C_OK = 3'd0, C_MISS_RD = 3'd1, C_MISS_WR = 3'd2,
                         C_INIT_WR = 3'd3, C_VIOL_RD = 3'd4, C_VIOL_WR = 3'd5,
                         C_MULTI = 3'd6;
  localparam logic [CNT_W:0] LAST_IDX = (CNT_W+1)'(ENTRIES - 1);

  logic [ENTRIES-1:0] e_v, e_sh, e_d, e_c;
  logic [1:0]         e_sz   [ENTRIES];
  logic [1:0]         e_pr   [ENTRIES];
  logic [7:0]         e_asid [ENTRIES];
  logic [VPN_W-1:0]   e_vpn  [ENTRIES];
  logic [PPN_W-1:0]   e_ppn  [ENTRIES];

  function automatic logic [31:0] page_mask(input logic [1:0] sz);
    case (sz)
      2'd0:    page_mask = 32'hFFFF_FC00;
      2'd1:    page_mask = 32'hFFFF_F000;
      2'd2:    page_mask = 32'hFFFF_0000;
      default: page_mask = 32'hFFF0_0000;
    endcase
  endfunction

  wire tag_chk = !lk_sv || !lk_priv;

  logic [ENTRIES-1:0] hit;
  logic [31:0]        s_mask;
  logic [PPN_W-1:0]   s_ppn;
  logic [1:0]         s_pr;
  logic               s_d, s_c;

  always_comb begin
    s_mask = '0; s_ppn = '0; s_pr = '0; s_d = 1'b0; s_c = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      hit[i] = e_v[i] && (!tag_chk || e_sh[i] || e_asid[i] == lk_asid) &&
               ((lk_addr & page_mask(e_sz[i])) == ({e_vpn[i], 10'b0} & page_mask(e_sz[i])));
      if (hit[i]) begin
        s_mask |= page_mask(e_sz[i]);
        s_ppn  |= e_ppn[i];
        s_pr   |= e_pr[i];
        s_d    |= e_d[i];
        s_c    |= e_c[i];
      end
    end
  end

  wire [31:0] ppn_base = 32'({s_ppn, 10'b0});
  wire [31:0] xlat     = (ppn_base & s_mask) | (lk_addr & ~s_mask);
  wire [2:0]  prot_idx = {s_pr, lk_priv};

  logic [2:0] code_n;
  always_comb begin
    if ($countones(hit) > 1)       code_n = C_MULTI;
    else if (hit == '0)            code_n = lk_write ? C_MISS_WR : C_MISS_RD;
    else begin
      case (prot_idx)
        3'd0, 3'd2:       code_n = lk_write ? C_VIOL_WR : C_VIOL_RD;
        3'd1, 3'd4, 3'd5: code_n = lk_write ? C_VIOL_WR : C_OK;
        default:          code_n = C_OK;
      endcase
      if (code_n == C_OK && lk_write && !s_d) code_n = C_INIT_WR;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      e_v <= '0;
    end else if (ld_en) begin
      e_v[ld_index]    <= ld_valid;
      e_sh[ld_index]   <= ld_shared;
      e_d[ld_index]    <= ld_dirty;
      e_c[ld_index]    <= ld_cache;
      e_sz[ld_index]   <= ld_size;
      e_pr[ld_index]   <= ld_prot;
      e_asid[ld_index] <= ld_asid;
      e_vpn[ld_index]  <= ld_vpn;
      e_ppn[ld_index]  <= ld_ppn;
    end
  end

  wire [CNT_W:0] cnt_inc = {1'b0, repl_count} + 1'b1;
  wire cnt_wrap = (repl_bound != '0 && cnt_inc > {1'b0, repl_bound}) || cnt_inc > LAST_IDX;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      repl_count <= '0;
      res_valid  <= 1'b0;
      res_code   <= C_OK;
      res_paddr  <= '0;
      res_cache  <= 1'b0;
    end else begin
      res_valid <= lk_valid;
      if (lk_valid) begin
        repl_count <= cnt_wrap ? '0 : cnt_inc[CNT_W-1:0];
        res_code   <= code_n;
        res_paddr  <= (code_n == C_OK) ? xlat : '0;
        res_cache  <= (code_n == C_OK) && s_c;
      end
    end
  end

  assert_code_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
    res_code <= C_MULTI);
  assert_result_timing_R10: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> res_valid);
  assert_no_spurious_result_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !res_valid);
  assert_counter_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> $stable(repl_count));
  assert_counter_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, repl_count} <= LAST_IDX);
  assert_paddr_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_code != C_OK) |-> (res_paddr == '0 && !res_cache));

endmodule

// File: tb/tlb_assoc_lookup_tb.sv
module tlb_assoc_lookup_tb_top;
  localparam int ENTRIES = 16;
  localparam int IDX_W = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic lk_valid = 0, lk_write = 0, lk_priv = 0, lk_sv = 0;
  logic [31:0] lk_addr = '0;
  logic [7:0] lk_asid = '0;
  logic res_valid, res_cache;
  logic [2:0] res_code;
  logic [31:0] res_paddr;
  logic ld_en = 0, ld_valid = 0, ld_shared = 0, ld_dirty = 0, ld_cache = 0;
  logic [IDX_W-1:0] ld_index = '0;
  logic [1:0] ld_size = '0, ld_prot = '0;
  logic [7:0] ld_asid = '0;
  logic [21:0] ld_vpn = '0;
  logic [18:0] ld_ppn = '0;
  logic [5:0] repl_bound = '0;
  logic [5:0] repl_count;

  int errors = 0, checks = 0;
  int exp_cnt = 0;

  always #2.5 clk = ~clk;

  tlb_assoc_lookup dut_i (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load(int idx, bit v, bit sh, bit d, bit c, int sz, int pr,
                      int asid, logic [31:0] va, logic [18:0] ppn);
    @(negedge clk);
    ld_en = 1; ld_index = IDX_W'(idx); ld_valid = v; ld_shared = sh; ld_dirty = d;
    ld_cache = c; ld_size = 2'(sz); ld_prot = 2'(pr); ld_asid = 8'(asid);
    ld_vpn = va[31:10]; ld_ppn = ppn;
    @(negedge clk);
    ld_en = 0;
  endtask

  task automatic lookup(string req, logic [31:0] a, bit wr, bit priv, bit sv,
                        int asid, int exp_code, logic [31:0] exp_pa, bit exp_c);
    @(negedge clk);
    lk_valid = 1; lk_addr = a; lk_write = wr; lk_priv = priv; lk_sv = sv;
    lk_asid = 8'(asid);
    @(negedge clk);
    lk_valid = 0;
    exp_cnt = exp_cnt + 1;
    if ((repl_bound != 0 && exp_cnt > int'(repl_bound)) || exp_cnt > ENTRIES - 1)
      exp_cnt = 0;
    check({req, " valid (R10)"}, 32'(res_valid), 1);
    check({req, " code"}, 32'(res_code), 32'(exp_code));
    check({req, " paddr (R4)"}, res_paddr, exp_pa);
    check({req, " cache (R4)"}, 32'(res_cache), 32'(exp_c));
    check({req, " counter (R9)"}, 32'(repl_count), 32'(exp_cnt));
  endtask

  task automatic t_reset;
    check("R11 reset res_valid", 32'(res_valid), 0);
    check("R9 reset counter", 32'(repl_count), 0);
    lookup("R11 empty read miss", 32'h0040_1ABC, 0, 1, 1, 5, 1, 0, 0);
    lookup("R8 empty write miss", 32'h0040_1ABC, 1, 1, 1, 5, 2, 0, 0);
  endtask

  task automatic t_asid;
    load(0, 1, 0, 1, 1, 1, 3, 5, 32'h0040_1000, 19'h123);
    lookup("R4 4K hit", 32'h0040_1ABC, 0, 0, 0, 5, 0, 32'h0004_8ABC, 1);
    lookup("R1 tag mismatch user", 32'h0040_1ABC, 0, 0, 1, 6, 1, 0, 0);
    lookup("R2 priv sv=1 ignores tag", 32'h0040_1ABC, 1, 1, 1, 6, 0, 32'h0004_8ABC, 1);
    lookup("R2 priv sv=0 checks tag", 32'h0040_1ABC, 1, 1, 0, 6, 2, 0, 0);
    @(negedge clk);
    check("R10 no result when idle", 32'(res_valid), 0);
  endtask

  task automatic t_sizes;
    load(1, 1, 1, 1, 0, 0, 3, 9, 32'h0080_0400, 19'h10);
    lookup("R3 1K top of page", 32'h0080_07FF, 0, 0, 0, 1, 0, 32'h0000_43FF, 0);
    lookup("R3 1K next page misses", 32'h0080_0800, 0, 0, 0, 1, 1, 0, 0);
    load(2, 1, 1, 1, 1, 3, 3, 0, 32'h0310_1C00, 19'h7FFFF);
    lookup("R3 1M hit", 32'h031A_BCDE, 0, 0, 0, 1, 0, 32'h1FFA_BCDE, 1);
    lookup("R3 1M outside", 32'h0320_0000, 1, 0, 0, 1, 2, 0, 0);
    load(3, 1, 1, 0, 0, 2, 0, 0, 32'h0400_0000, 19'h20);
    lookup("R3 64K hit priv read", 32'h0400_F234, 0, 1, 0, 0, 0, 32'h0000_F234, 0);
  endtask

  task automatic t_prot;
    lookup("R6 prot0 priv write", 32'h0400_1234, 1, 1, 0, 0, 5, 0, 0);
    lookup("R6 prot0 user read", 32'h0400_1234, 0, 0, 0, 0, 4, 0, 0);
    lookup("R6 prot0 user write", 32'h0400_1234, 1, 0, 0, 0, 5, 0, 0);
    load(4, 1, 1, 0, 0, 1, 2, 0, 32'h0500_0000, 19'h100);
    lookup("R6 prot2 user read", 32'h0500_0010, 0, 0, 0, 0, 0, 32'h0004_0010, 0);
    lookup("R6 prot2 user write", 32'h0500_0010, 1, 0, 0, 0, 5, 0, 0);
    lookup("R6 prot2 priv write", 32'h0500_0010, 1, 1, 0, 0, 5, 0, 0);
    load(5, 1, 1, 0, 0, 1, 1, 0, 32'h0600_0000, 19'h0);
    lookup("R6 prot1 user read", 32'h0600_0020, 0, 0, 0, 0, 4, 0, 0);
    lookup("R7 prot1 priv write clean", 32'h0600_0020, 1, 1, 0, 0, 3, 0, 0);
    lookup("R6 prot1 priv read", 32'h0600_0020, 0, 1, 0, 0, 0, 32'h0000_0020, 0);
    load(5, 1, 1, 1, 0, 1, 1, 0, 32'h0600_0000, 19'h0);
    lookup("R7 prot1 priv write dirty", 32'h0600_0020, 1, 1, 0, 0, 0, 32'h0000_0020, 0);
  endtask

  task automatic t_multi;
    load(6, 1, 0, 1, 0, 0, 3, 5, 32'h0040_1000, 19'h55);
    lookup("R5 multiple read", 32'h0040_1004, 0, 0, 0, 5, 6, 0, 0);
    lookup("R5 multiple write", 32'h0040_1004, 1, 0, 0, 5, 6, 0, 0);
    lookup("R5 single in larger page", 32'h0040_1ABC, 0, 0, 0, 5, 0, 32'h0004_8ABC, 1);
    load(0, 0, 0, 1, 1, 1, 3, 5, 32'h0040_1000, 19'h123);
    lookup("R11 invalidated entry", 32'h0040_1ABC, 0, 0, 0, 5, 1, 0, 0);
  endtask

  task automatic t_counter;
    for (int k = 0; k < 18; k++)
      lookup("R9 free wrap", 32'hFFFF_0000, 0, 0, 0, 0, 1, 0, 0);
    @(negedge clk);
    repl_bound = 6'd3;
    for (int k = 0; k < 6; k++)
      lookup("R9 bound wrap", 32'hFFFF_0000, 1, 0, 0, 0, 2, 0, 0);
    repeat (3) @(negedge clk);
    check("R9 hold when idle", 32'(repl_count), 32'(exp_cnt));
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_asid();
        t_sizes();
        t_prot();
        t_multi();
        t_counter();
      end
      begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule